// File: doc/BRIEF.md
# Eight-Channel External Interrupt Controller

This block watches eight asynchronous request pins and turns activity on them into a single interrupt request for the processor. Every pin is first brought into the core clock domain. A per-channel trigger selector then decides what counts as a request on that pin: a low level, a high level, a rising edge or a falling edge. When a channel's trigger condition is seen, a sticky cause flag for that channel is set. The interrupt output is raised whenever at least one channel has its cause flag set and is also unmasked.

Software talks to the block through a small byte-wide register port with four consecutive addresses starting at a base address (default 0x30). The first address is the per-channel mask (enable), and the second is the cause flags. The last two hold the 16-bit trigger selection, two bits per channel. Flags are cleared by writing zero to the matching cause bit.

Top module: `extint_ctrl`

## Requirements
- R1: While reset is asserted, the enable, cause and trigger registers all read 0x00 and the interrupt output is low.
- R2: The trigger register is 16 bits, with the low byte at base+2 and the high byte at base+3. Channel n uses bits 2n+1:2n, so channels 0–3 are in the low byte and channels 4–7 in the high byte. The 2-bit codes are 00 for low level, 01 for high level, 10 for rising edge and 11 for falling edge.
- R3: In low-level mode, a channel's flag is set on every cycle in which its synchronised input is 0.
- R4: In high-level mode, a channel's flag is set on every cycle in which its synchronised input is 1.
- R5: In rising-edge mode, a flag is set once per 0-to-1 transition of the synchronised input. An input that stays high does not set it again after a clear.
- R6: In falling-edge mode, a flag is set once per 1-to-0 transition of the synchronised input. An input that stays low does not set it again after a clear.
- R7: Cause flags are set whether or not the channel is enabled, and a channel whose enable bit is 0 never raises the interrupt.
- R8: Writing the cause register at base+1 clears every flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. Flags change in no other way except by detection.
- R9: When a detection and a clear of the same channel fall in the same cycle, the flag stays set. A level that is still present therefore keeps the flag set.
- R10: The interrupt output is the registered OR over channels of flag AND enable. A pin change made before clock edge k becomes visible in the cause flag after edge k+2 and at the interrupt output after edge k+3.
- R11: Reads from any address outside base..base+3 return 0x00, and writes to such addresses change no register.
- R12: The enable register at base+0 holds one mask bit per channel (bit n for channel n) and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Asynchronous request pins, bit n is channel n |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Registered active-high interrupt request |

## Verification
A wrong synchroniser or edge history shows up as a flag that appears one cycle early or late, or as an edge flag that is raised twice. The cause register reveals this on the cycle after the faulty detection, and the interrupt output reveals it one cycle later. A corrupted mask or trigger register is visible at its read address in the same cycle. An error in clear or detection priority leaves a flag reading wrong immediately after the write edge. A reference model compares the read data and the interrupt output on every clock, so any such divergence is reported within one or two cycles of its cause.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        logic now;
        logic old;
    } pin_hist_t;

    function automatic logic trig_match(trig_e sel, pin_hist_t h);
        logic r;
        case (sel)
            TRIG_LOW:  r = !h.now;
            TRIG_HIGH: r = h.now;
            TRIG_RISE: r = h.now && !h.old;
            default:   r = !h.now && h.old;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin,
    output logic [NCH-1:0] cur,
    output logic [NCH-1:0] prv
);
    logic [NCH-1:0] meta_q;
    logic [NCH-1:0] cur_q;
    logic [NCH-1:0] prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= pin;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur = cur_q;
    assign prv = prv_q;
endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [2*NCH-1:0] sel,
    input  logic [NCH-1:0]   cur,
    input  logic [NCH-1:0]   prv,
    output logic [NCH-1:0]   hit
);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pin_hist_t h;
        trig_e     t;
        assign h.now = cur[n];
        assign h.old = prv[n];
        assign t     = trig_e'(sel[2*n +: 2]);
        assign hit[n] = trig_match(t, h);
    end
endmodule

// File: rtl/extint_regs.sv
module extint_regs #(
    parameter int          NCH  = 8,
    parameter int          AW   = 8,
    parameter logic [AW-1:0] BASE = 8'h30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic [NCH-1:0]   hit,
    output logic [7:0]       rdata,
    output logic [NCH-1:0]   en,
    output logic [NCH-1:0]   flags,
    output logic [2*NCH-1:0] sel
);
    localparam int MODE_BYTES = (2 * NCH + 7) / 8;
    localparam int MODE_W     = MODE_BYTES * 8;
    localparam logic [AW-1:0] A_EN    = BASE;
    localparam logic [AW-1:0] A_CAUSE = BASE + AW'(1);
    localparam logic [AW-1:0] A_MODE0 = BASE + AW'(2);

    logic [NCH-1:0]    en_q;
    logic [NCH-1:0]    flag_q;
    logic [MODE_W-1:0] mode_q;
    logic [NCH-1:0]    clr_mask;

    always_comb begin
        clr_mask = '0;
        if (wr && addr == A_CAUSE) clr_mask = ~wdata[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (wr && addr == A_EN) en_q <= wdata[NCH-1:0];
            flag_q <= hit | (flag_q & ~clr_mask);
        end
    end

    for (genvar b = 0; b < MODE_BYTES; b++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst) mode_q[8*b +: 8] <= '0;
            else if (wr && addr == A_MODE0 + AW'(b)) mode_q[8*b +: 8] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_EN)    rdata[NCH-1:0] = en_q;
        if (addr == A_CAUSE) rdata[NCH-1:0] = flag_q;
        for (int b = 0; b < MODE_BYTES; b++) begin
            if (addr == A_MODE0 + AW'(b)) rdata = mode_q[8*b +: 8];
        end
    end

    assign en    = en_q;
    assign flags = flag_q;
    assign sel   = mode_q[2*NCH-1:0];
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
    parameter int            NCH  = 8,
    parameter int            AW   = 8,
    parameter logic [AW-1:0] BASE = 8'h30
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req_in,
    input  logic [AW-1:0]  reg_addr,
    input  logic           reg_wr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    output logic           irq_out
);
    logic [NCH-1:0]   cur_s;
    logic [NCH-1:0]   prv_s;
    logic [NCH-1:0]   hit_s;
    logic [NCH-1:0]   en_s;
    logic [NCH-1:0]   flag_s;
    logic [2*NCH-1:0] sel_s;
    logic             irq_q;

    extint_sync #(.NCH(NCH)) sync_i (
        .clk(clk), .rst(rst), .pin(req_in), .cur(cur_s), .prv(prv_s)
    );

    extint_detect #(.NCH(NCH)) det_i (
        .sel(sel_s), .cur(cur_s), .prv(prv_s), .hit(hit_s)
    );

    extint_regs #(.NCH(NCH), .AW(AW), .BASE(BASE)) regs_i (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .hit(hit_s), .rdata(reg_rdata), .en(en_s), .flags(flag_s), .sel(sel_s)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flag_s & en_s);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/extint_checker.sv
module extint_checker #(
    parameter int            NCH  = 8,
    parameter int            AW   = 8,
    parameter logic [AW-1:0] BASE = 8'h30
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    reg_addr,
    input logic             reg_wr,
    input logic [7:0]       reg_rdata,
    input logic             irq_out,
    input logic [NCH-1:0]   en,
    input logic [NCH-1:0]   flags,
    input logic [2*NCH-1:0] sel
);
    localparam int LO = int'(BASE);
    localparam int HI = int'(BASE) + 1 + (2 * NCH + 7) / 8;

    logic unused_addr;
    logic wr_cause;
    logic wr_en;
    logic wr_mode;
    assign unused_addr = (int'(reg_addr) < LO) || (int'(reg_addr) > HI);
    assign wr_cause    = reg_wr && (int'(reg_addr) == LO + 1);
    assign wr_en       = reg_wr && (int'(reg_addr) == LO);
    assign wr_mode     = reg_wr && (int'(reg_addr) > LO + 1) && (int'(reg_addr) <= HI);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && en == '0 && sel == '0 && !irq_out));

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_out == |($past(flags) & $past(en))));

    p_flag_only_cleared_by_write_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_cause |=> ((flags & $past(flags)) == $past(flags)));

    p_unused_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        unused_addr |-> reg_rdata == 8'h00);

    p_enable_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_mode |=> $stable(sel));
endmodule

bind extint_ctrl extint_checker #(.NCH(NCH), .AW(AW), .BASE(BASE)) chk_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .irq_out(irq_out),
    .en(en_s), .flags(flag_s), .sel(sel_s)
);

// File: tb/extint_ctrl_tb_top.sv
module extint_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = 8'h00;
    logic [7:0] reg_addr = 8'h31;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    extint_ctrl dut_i (
        .clk(clk), .rst(rst), .req_in(req_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // behavioural reference model
    bit [7:0]  hist[$] = '{8'h00, 8'h00, 8'h00};
    bit [7:0]  m_en = 0, m_flag = 0;
    bit [15:0] m_mode = 0;
    bit        m_irq = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{8'h00, 8'h00, 8'h00};
            m_en = 0; m_flag = 0; m_mode = 0; m_irq = 0;
        end else begin
            bit [7:0] s, p, hit, keep;
            s = hist[1];
            p = hist[2];
            for (int n = 0; n < 8; n++) begin
                case ({m_mode[2*n+1], m_mode[2*n]})
                    2'b00: hit[n] = !s[n];
                    2'b01: hit[n] = s[n];
                    2'b10: hit[n] = s[n] && !p[n];
                    default: hit[n] = !s[n] && p[n];
                endcase
            end
            keep = (reg_wr && reg_addr == 8'h31) ? reg_wdata : 8'hFF;
            m_irq = |(m_flag & m_en);
            m_flag = hit | (m_flag & keep);
            if (reg_wr && reg_addr == 8'h30) m_en = reg_wdata;
            if (reg_wr && reg_addr == 8'h32) m_mode[7:0] = reg_wdata;
            if (reg_wr && reg_addr == 8'h33) m_mode[15:8] = reg_wdata;
            hist.push_front(req_in);
            void'(hist.pop_back());
        end
    end

    function automatic bit [7:0] m_read(bit [7:0] a);
        case (a)
            8'h30: return m_en;
            8'h31: return m_flag;
            8'h32: return m_mode[7:0];
            8'h33: return m_mode[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            string t;
            case (reg_addr)
                8'h30: t = "R12 rdata";
                8'h31: t = "R8 rdata";
                8'h32, 8'h33: t = "R2 rdata";
                default: t = "R11 rdata";
            endcase
            chk(t, reg_rdata, m_read(reg_addr));
            chk("R10 irq", irq_out, m_irq);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(bit [7:0] a, bit [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(bit [7:0] a, output bit [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        bit [7:0] d;
        // R1 reset state
        tick(2);
        for (int a = 8'h30; a <= 8'h33; a++) begin
            reg_addr = 8'(a);
            #1 chk("R1 reset reg", reg_rdata, 0);
        end
        chk("R1 reset irq", irq_out, 0);
        @(negedge clk); rst = 1'b0;

        // R3 low level (default mode) sets flags; R7 no irq while masked
        tick(4);
        rreg(8'h31, d); chk("R3 low-level flags", d, 8'hFF);
        chk("R7 masked irq", irq_out, 0);

        // R2 all channels high level
        wreg(8'h32, 8'h55); wreg(8'h33, 8'h55);
        rreg(8'h32, d); chk("R2 mode lo", d, 8'h55);
        rreg(8'h33, d); chk("R2 mode hi", d, 8'h55);
        wreg(8'h31, 8'h00);
        rreg(8'h31, d); chk("R8 clear all", d, 8'h00);
        wreg(8'h30, 8'hFF);
        rreg(8'h30, d); chk("R12 enable readback", d, 8'hFF);

        // R4 / R10 timing on channel 2
        rreg(8'h31, d);
        req_in[2] = 1'b1;
        tick(2); #1 chk("R10 flag not yet", reg_rdata[2], 0);
        tick(1); #1 chk("R4 high-level flag after k+2", reg_rdata[2], 1);
        chk("R10 irq not yet", irq_out, 0);
        tick(1); #1 chk("R10 irq after k+3", irq_out, 1);
        req_in[2] = 1'b0;
        tick(4);
        wreg(8'h31, 8'hFB);
        rreg(8'h31, d); chk("R8 clear bit2", d, 8'h00);

        // R8 write-one keeps
        req_in = 8'h24; tick(4); req_in = 8'h00; tick(4);
        wreg(8'h31, 8'hDF);
        rreg(8'h31, d); chk("R8 keep bit2 clear bit5", d, 8'h04);
        wreg(8'h31, 8'h00);

        // R9 detection wins over clear
        req_in[1] = 1'b1; tick(5);
        wreg(8'h31, 8'h00);
        rreg(8'h31, d); chk("R9 level survives clear", d, 8'h02);
        req_in[1] = 1'b0; tick(4);
        wreg(8'h31, 8'h00);

        // R5 rising edge channel 0
        wreg(8'h32, 8'h56); wreg(8'h31, 8'h00);
        req_in[0] = 1'b1; tick(5);
        rreg(8'h31, d); chk("R5 rise sets", d[0], 1);
        wreg(8'h31, 8'h00); tick(4);
        rreg(8'h31, d); chk("R5 steady high no reset", d[0], 0);
        req_in[0] = 1'b0; tick(5);
        rreg(8'h31, d); chk("R5 fall ignored", d[0], 0);

        // R6 falling edge channel 4
        req_in[4] = 1'b1;
        wreg(8'h33, 8'h57); tick(4);
        wreg(8'h31, 8'h00);
        rreg(8'h31, d); chk("R6 rise ignored", d[4], 0);
        req_in[4] = 1'b0; tick(5);
        rreg(8'h31, d); chk("R6 fall sets", d[4], 1);
        wreg(8'h31, 8'h00); tick(4);
        rreg(8'h31, d); chk("R6 steady low no reset", d[4], 0);

        // R3 low level channel 7
        wreg(8'h33, 8'h17); tick(4);
        rreg(8'h31, d); chk("R3 low-level ch7", d[7], 1);

        // R7 masked channels
        wreg(8'h30, 8'h00); tick(3);
        rreg(8'h31, d); chk("R7 flag set while masked", d[7], 1);
        chk("R7 irq low while masked", irq_out, 0);

        // R11 unused addresses
        wreg(8'h34, 8'hFF); wreg(8'h2F, 8'hFF);
        rreg(8'h34, d); chk("R11 read 0x34", d, 0);
        rreg(8'h2F, d); chk("R11 read 0x2F", d, 0);
        rreg(8'h30, d); chk("R11 enable untouched", d, 8'h00);
        rreg(8'h33, d); chk("R11 mode untouched", d, 8'h17);

        tick(3);
        summary();
    end
endmodule